// File: doc/BRIEF.md
# PHY Test-Port Register Writer

This block writes one configuration register inside a PHY through the PHY's test port. The port has four kinds of pin: a strobe that acts as a slow clock, an enable line, a clear line and an 8-bit bus. A write request carries an 8-bit register code and an 8-bit value. The block latches both, then drives a fixed pin sequence on the port. The sequence first clears the port. It then presents the code with enable high, so that the falling edge of the strobe loads the code as a register address. Last, it presents the value with enable low, so that the next rising edge of the strobe writes the value. For example, code 0x44 selects the PHY's high-speed frequency-range register.

Every step of the sequence holds its pin levels for `PHASE_CYCLES` system-clock cycles, so the PHY sees setup and hold time around every strobe edge. The bus and enable change only in cycles where the strobe is steady. A request is taken only while the block is idle. The block reports busy until the write finishes, then gives a one-cycle done pulse.

The controller has ten states, listed here in order. IDLE waits for a request. CLEAR raises the clear line. CLR_REL lowers it again. STB_UP raises the strobe. ADDR_SET drives enable and the code. ADDR_FALL drops the strobe. DATA_SET drops enable and drives the value. DATA_RISE raises the strobe. STB_DOWN lowers the strobe. DONE raises the done pulse.

The transitions are as follows. IDLE goes to CLEAR when a request arrives. Each timed state from CLEAR to STB_DOWN moves to the next state in the list when its phase timer expires. STB_DOWN moves to DONE, and DONE always returns to IDLE after one cycle.

Top module: `tport_writer`

## Requirements
- R1: While reset is applied and after it is released, with no request, all port pins are low, the bus is 0x00, and busy and done are low.
- R2: A request sampled high at a clock edge while idle is accepted, and busy is high from the next cycle. The code and value present at that edge are the ones written. Changes on code_i and data_i after that edge have no effect on the port.
- R3: The first phase drives clear high, with strobe low, enable low and bus 0x00. The second phase returns clear low, with all other pins unchanged.
- R4: The third phase raises the strobe while enable stays low and the bus stays 0x00.
- R5: The fourth phase drives enable high and places the code on the bus, with the strobe still high. The fifth phase lowers the strobe and keeps enable and the code steady.
- R6: The sixth phase drops enable and places the value on the bus, with the strobe low. The seventh phase raises the strobe and keeps the value steady.
- R7: The eighth phase returns the strobe low and keeps the value on the bus. Next comes exactly one cycle with done high, with busy still high and all pins low. After that cycle the block is idle.
- R8: In any cycle where the strobe changes level, the bus and enable keep the values they had in the previous cycle.
- R9: A request while busy is high, including the done cycle, is ignored. It changes neither the sequence nor the written code and value, and it does not start a new write.
- R10: Clear is never high together with enable or the strobe.
- R11: A PHY model that captures the bus on a falling strobe edge while enable is high, and on a rising edge while enable is low, ends holding the requested code and value.
- R12: Each of the eight phases lasts exactly PHASE_CYCLES cycles, so busy stays high for 8*PHASE_CYCLES+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, sampled while idle |
| code_i | input | BUS_W | Register code to write |
| data_i | input | BUS_W | Value to write |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| tp_clr_o | output | 1 | Test port clear line |
| tp_stb_o | output | 1 | Test port strobe |
| tp_en_o | output | 1 | Test port enable |
| tp_bus_o | output | BUS_W | Test port bus |

## Verification
The outputs decode the registered state directly. When a request is accepted at clock edge k, the port shows the first phase in the cycle after edge k. Phase p then occupies cycle offsets p*PHASE_CYCLES to (p+1)*PHASE_CYCLES-1, counted from that cycle. The done cycle falls at offset 8*PHASE_CYCLES, and busy is low one cycle after it. The bench drives inputs and samples all outputs on the falling clock edge. At each offset it compares the pins against a reference function of that offset, so every phase and its length are checked in the exact cycle they are due. The latched PHY values are checked once the block is back in idle.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_CLEAR     = 4'd1,
        ST_CLR_REL   = 4'd2,
        ST_STB_UP    = 4'd3,
        ST_ADDR_SET  = 4'd4,
        ST_ADDR_FALL = 4'd5,
        ST_DATA_SET  = 4'd6,
        ST_DATA_RISE = 4'd7,
        ST_STB_DOWN  = 4'd8,
        ST_DONE      = 4'd9
    } tpw_state_e;

    typedef enum logic [1:0] {
        BUS_ZERO = 2'd0,
        BUS_CODE = 2'd1,
        BUS_DATA = 2'd2
    } tpw_bus_sel_e;

    typedef struct packed {
        logic         clr;
        logic         stb;
        logic         en;
        tpw_bus_sel_e sel;
    } tpw_pins_t;

    localparam int TPW_NUM_PHASES = 8;

endpackage

// File: rtl/tpw_timer.sv
module tpw_timer #(
    parameter int PHASE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic last_o
);
    localparam int CW = (PHASE_CYCLES < 2) ? 1 : $clog2(PHASE_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/tpw_capture.sv
module tpw_capture #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [BUS_W-1:0] code_i,
    input  logic [BUS_W-1:0] data_i,
    output logic [BUS_W-1:0] code_o,
    output logic [BUS_W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            data_o <= '0;
        end else if (take_i) begin
            code_o <= code_i;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/tpw_fsm.sv
module tpw_fsm
    import tpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       last_i,
    output tpw_state_e state_o,
    output logic       load_o,
    output logic       take_o
);
    tpw_state_e state_q;
    tpw_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_i)  state_d = ST_CLEAR;
            ST_CLEAR:     if (last_i) state_d = ST_CLR_REL;
            ST_CLR_REL:   if (last_i) state_d = ST_STB_UP;
            ST_STB_UP:    if (last_i) state_d = ST_ADDR_SET;
            ST_ADDR_SET:  if (last_i) state_d = ST_ADDR_FALL;
            ST_ADDR_FALL: if (last_i) state_d = ST_DATA_SET;
            ST_DATA_SET:  if (last_i) state_d = ST_DATA_RISE;
            ST_DATA_RISE: if (last_i) state_d = ST_STB_DOWN;
            ST_STB_DOWN:  if (last_i) state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign load_o  = (state_d != state_q);
    assign take_o  = (state_q == ST_IDLE) && req_i;
endmodule

// File: rtl/tpw_pindrive.sv
module tpw_pindrive
    import tpw_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  tpw_state_e       state_i,
    input  logic [BUS_W-1:0] code_i,
    input  logic [BUS_W-1:0] data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             clr_o,
    output logic             stb_o,
    output logic             en_o,
    output logic [BUS_W-1:0] bus_o
);
    tpw_pins_t pins;

    always_comb begin
        pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_ZERO};
        unique case (state_i)
            ST_IDLE:      pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_ZERO};
            ST_CLEAR:     pins = '{clr: 1'b1, stb: 1'b0, en: 1'b0, sel: BUS_ZERO};
            ST_CLR_REL:   pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_ZERO};
            ST_STB_UP:    pins = '{clr: 1'b0, stb: 1'b1, en: 1'b0, sel: BUS_ZERO};
            ST_ADDR_SET:  pins = '{clr: 1'b0, stb: 1'b1, en: 1'b1, sel: BUS_CODE};
            ST_ADDR_FALL: pins = '{clr: 1'b0, stb: 1'b0, en: 1'b1, sel: BUS_CODE};
            ST_DATA_SET:  pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_DATA};
            ST_DATA_RISE: pins = '{clr: 1'b0, stb: 1'b1, en: 1'b0, sel: BUS_DATA};
            ST_STB_DOWN:  pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_DATA};
            ST_DONE:      pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_ZERO};
            default:      pins = '{clr: 1'b0, stb: 1'b0, en: 1'b0, sel: BUS_ZERO};
        endcase
    end

    always_comb begin
        unique case (pins.sel)
            BUS_CODE: bus_o = code_i;
            BUS_DATA: bus_o = data_i;
            default:  bus_o = '0;
        endcase
    end

    assign clr_o  = pins.clr;
    assign stb_o  = pins.stb;
    assign en_o   = pins.en;
    assign busy_o = (state_i != ST_IDLE);
    assign done_o = (state_i == ST_DONE);
endmodule

// File: rtl/tport_writer.sv
module tport_writer
    import tpw_pkg::*;
#(
    parameter int BUS_W        = 8,
    parameter int PHASE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [BUS_W-1:0] code_i,
    input  logic [BUS_W-1:0] data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             tp_clr_o,
    output logic             tp_stb_o,
    output logic             tp_en_o,
    output logic [BUS_W-1:0] tp_bus_o
);
    tpw_state_e       state;
    logic             load;
    logic             take;
    logic             last;
    logic [BUS_W-1:0] code_q;
    logic [BUS_W-1:0] data_q;

    tpw_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .last_i  (last),
        .state_o (state),
        .load_o  (load),
        .take_o  (take)
    );

    tpw_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .last_o (last)
    );

    tpw_capture #(.BUS_W(BUS_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .code_i (code_i),
        .data_i (data_i),
        .code_o (code_q),
        .data_o (data_q)
    );

    tpw_pindrive #(.BUS_W(BUS_W)) u_pins (
        .state_i (state),
        .code_i  (code_q),
        .data_i  (data_q),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .clr_o   (tp_clr_o),
        .stb_o   (tp_stb_o),
        .en_o    (tp_en_o),
        .bus_o   (tp_bus_o)
    );
endmodule

// File: rtl/tpw_checker.sv
module tpw_checker #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             tp_clr_o,
    input logic             tp_stb_o,
    input logic             tp_en_o,
    input logic [BUS_W-1:0] tp_bus_o
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o); // R2

    AST_EDGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_stb_o != $past(tp_stb_o)) |-> (tp_bus_o == $past(tp_bus_o) && tp_en_o == $past(tp_en_o))); // R8

    AST_FALL_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tp_stb_o) && busy_o && !done_o && $past(tp_en_o) |-> tp_en_o); // R5

    AST_RISE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tp_stb_o) |-> !tp_en_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R7

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R7

    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clr_o |-> (!tp_en_o && !tp_stb_o)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!tp_clr_o && !tp_stb_o && !tp_en_o && tp_bus_o == '0)); // R1
endmodule

bind tport_writer tpw_checker #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/test_tport_writer.sv
`timescale 1ns/1ps
module test_tport_writer;
    localparam int W = 8;
    localparam int N = 4;
    localparam int LEN = 8 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [W-1:0] code = '0;
    logic [W-1:0] data = '0;
    logic         busy, done, tclr, tstb, ten;
    logic [W-1:0] tbus;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [W-1:0] phy_addr = '0;
    logic [W-1:0] phy_val  = '0;

    always #5 clk = ~clk;

    tport_writer #(.BUS_W(W), .PHASE_CYCLES(N)) i_tport_writer (
        .clk(clk), .rst_n(rst_n), .req_i(req), .code_i(code), .data_i(data),
        .busy_o(busy), .done_o(done), .tp_clr_o(tclr), .tp_stb_o(tstb),
        .tp_en_o(ten), .tp_bus_o(tbus)
    );

    // PHY side model for R11
    always @(negedge tstb) if (ten)  phy_addr <= tbus;
    always @(posedge tstb) if (!ten) phy_val  <= tbus;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {busy, done, clr, stb, en, bus}
    function automatic logic [12:0] expect_pins(int j, logic [W-1:0] c, logic [W-1:0] d);
        int p = j / N;
        case (p)
            0: return {5'b10100, 8'h00};
            1: return {5'b10000, 8'h00};
            2: return {5'b10010, 8'h00};
            3: return {5'b10011, c};
            4: return {5'b10001, c};
            5: return {5'b10000, d};
            6: return {5'b10010, d};
            7: return {5'b10000, d};
            default: return {5'b11000, 8'h00};
        endcase
    endfunction

    function automatic string phase_tag(int j);
        case (j / N)
            0, 1: return "R3";
            2:    return "R4";
            3, 4: return "R5";
            5, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_write(input logic [W-1:0] c, input logic [W-1:0] d,
                             input int noise_pct, input logic late_req);
        logic [12:0] prev;
        logic [12:0] obs;
        int busy_cnt = 0;
        int edge_bad = 0;
        int clr_bad  = 0;
        req = 1'b1; code = c; data = d;
        @(negedge clk);
        prev = '0;
        for (int j = 0; j <= LEN; j++) begin
            obs = {busy, done, tclr, tstb, ten, tbus};
            check($sformatf("%s+R12 j=%0d", phase_tag(j), j), 32'(obs), 32'(expect_pins(j, c, d)));
            if (busy) busy_cnt++;
            if (j > 0 && obs[9] != prev[9] && obs[8:0] != prev[8:0]) edge_bad++;
            if (tclr && (tstb || ten)) clr_bad++;
            prev = obs;
            // R2 / R9: disturb inputs and request while busy
            code = W'($urandom);
            data = W'($urandom);
            req  = (($urandom % 100) < noise_pct) || (late_req && j == LEN);
            @(negedge clk);
        end
        req = 1'b0;
        check("R9 idle after done", 32'(busy), 32'd0);
        check("R12 busy length", 32'(busy_cnt), 32'(LEN + 1));
        check("R8 steady at strobe edge", 32'(edge_bad), 32'd0);
        check("R10 clear alone", 32'(clr_bad), 32'd0);
        check("R11 phy code", 32'(phy_addr), 32'(c));
        check("R11 phy value", 32'(phy_val), 32'(d));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset pins", 32'({busy, done, tclr, tstb, ten, tbus}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle pins", 32'({busy, done, tclr, tstb, ten, tbus}), 32'd0);

        // directed: frequency-range code, boundary values
        run_write(8'h44, 8'h00, 0, 1'b0);
        run_write(8'hFF, 8'hFF, 0, 1'b0);
        run_write(8'h00, 8'hA5, 50, 1'b1);   // R9 noise incl. done cycle
        // back-to-back: a request right at idle is accepted
        run_write(8'h3C, 8'hC3, 100, 1'b1);  // R9 req held during whole write
        for (int t = 0; t < 16; t++) begin
            run_write(W'($urandom), W'($urandom), 30, t[0]);
            repeat ($urandom % 3) @(negedge clk);
        end
        check("R1 idle at end", 32'({busy, done, tclr, tstb, ten, tbus}), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule